// File: doc/BRIEF.md
# Standby Wake-up and Clock Settling Controller

This block sequences a small microcontroller out of its low-power software standby state. While the chip runs, a sleep request parks the chip when the standby-enable bit is set. In that state both the oscillator enable and the chip-wide clock gate are low. Once parked, the chip can be woken by a wake source. A non-maskable interrupt always wakes it. Three maskable interrupt lines wake it only when each is enabled and not masked. When an interrupt wakes the chip, the oscillator restarts first. A programmable settling counter then runs. Only after it expires does the clock gate open, with a one-cycle pulse that starts interrupt handling.

A low level on the reset pin skips the settling wait. It turns on the oscillator and the clock at once. When the pin returns high, a one-cycle pulse starts reset handling. A low level on the hardware-standby pin takes priority over everything else in every state. It shuts down the oscillator and the clock. When the pin is released, the block passes through the reset-hold path.

The settling length is a power of two. A 3-bit select code sets the base count, and codes above 5 are treated as 5. A 2-bit divider code stretches that count by 1, 2, 4 or 8. The external pins pass through a synchronizer of `SYNC_STAGES` flops before the sequencer sees them.

Top module: `standby_wake_ctrl`

## Requirements
- R1: After the block reset the controller is in the running state: osc_en=1, clk_gate_en=1, irq_start=0, rst_start=0, hw_sby=0.
- R2: A sleep_req sampled while sby_en=1 in the running state drives osc_en and clk_gate_en to 0 on the next clock edge. With sby_en=0, a sleep_req has no effect and both outputs stay 1.
- R3: A high nmi_pin wakes the chip from standby whatever the values of irq_en and irq_mask.
- R4: irq_pin[n] wakes the chip from standby only when irq_en[n]=1 and irq_mask=0. Otherwise osc_en stays 0.
- R5: After an interrupt wake, osc_en=1 and clk_gate_en=0 hold for exactly W = 2^(BASE_LOG2 + min(settle_sel,5) + div_sel) cycles. clk_gate_en rises after that, and clk_gate_en is never 1 while osc_en is 0.
- R6: irq_start is a one-cycle pulse. It is high exactly in the first cycle in which clk_gate_en is 1 after the settling wait.
- R7: A low res_pin_n in standby raises osc_en and clk_gate_en SYNC_STAGES+1 cycles after the pin falls, with no settling wait. rst_start pulses for one cycle SYNC_STAGES+1 cycles after the pin rises, and not before.
- R8: A low res_pin_n during settling aborts the count and supplies the clock at once. No irq_start is issued for the aborted wake.
- R9: A low hwsby_pin_n in any state gives hw_sby=1, osc_en=0 and clk_gate_en=0 SYNC_STAGES+1 cycles later. A low reset pin does not override it.
- R10: On release of hwsby_pin_n the clock is supplied (hw_sby=0, clk_gate_en=1) SYNC_STAGES+1 cycles later. rst_start pulses one cycle after that if res_pin_n is high, or once res_pin_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Block reset, asynchronous assert, active low |
| sleep_req | input | 1 | Request to enter software standby |
| sby_en | input | 1 | Standby-enable control bit |
| nmi_pin | input | 1 | Non-maskable interrupt pin, active high |
| irq_pin | input | N_IRQ | Maskable interrupt pins, active high |
| irq_en | input | N_IRQ | Per-line interrupt enable bits |
| irq_mask | input | 1 | CPU-level mask of the maskable interrupts |
| res_pin_n | input | 1 | Reset pin, active low |
| hwsby_pin_n | input | 1 | Hardware-standby pin, active low |
| settle_sel | input | SEL_W | Settling-length select code |
| div_sel | input | DIV_W | Settling stretch factor code |
| osc_en | output | 1 | Oscillator enable |
| clk_gate_en | output | 1 | Chip-wide clock gate enable |
| irq_start | output | 1 | One-cycle start of interrupt handling |
| rst_start | output | 1 | One-cycle start of reset handling |
| hw_sby | output | 1 | Hardware standby is active |

## Verification
The bench builds the block with BASE_LOG2=2, SYNC_STAGES=2 and N_IRQ=3. This shrinks the wait range to 4 through 1024 cycles, so every select code and every divider code can be timed cycle-exact in a short run. That range includes the saturating codes 5 to 7 and the longest stretch. The default BASE_LOG2=13 gives 8192 to 2^21 cycles, which covers the millisecond-scale settling needed by a crystal. The synchronizer depth of two fixes the pin-to-state latency at three cycles, and the reset and hardware-standby checks sample at that exact cycle.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_STANDBY    = 3'd1,
    ST_SETTLING   = 3'd2,
    ST_RST_HOLD   = 3'd3,
    ST_HW_STANDBY = 3'd4
  } sbw_state_e;

  // log2 of the settling length: select code saturates at sat, divider adds octaves
  function automatic int unsigned wait_log2(int unsigned base, int unsigned sel,
                                            int unsigned dv, int unsigned sat);
    int unsigned s;
    s = (sel > sat) ? sat : sel;
    return base + s + dv;
  endfunction

endpackage

// File: rtl/sbw_sync.sv
module sbw_sync #(
  parameter int                 WIDTH   = 1,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= RST_VAL;
        else        pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/sbw_wake_qual.sv
module sbw_wake_qual #(
  parameter int N_IRQ = 3
) (
  input  logic             nmi_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             irq_mask_i,
  output logic             wake_o
);

  logic [N_IRQ-1:0] line_ok;

  generate
    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
      assign line_ok[g] = irq_i[g] & irq_en_i[g] & ~irq_mask_i;
    end
  endgenerate

  // non-maskable source bypasses enable and mask
  assign wake_o = nmi_i | (|line_ok);

endmodule

// File: rtl/sbw_settle_timer.sv
module sbw_settle_timer #(
  parameter int BASE_LOG2 = 13,
  parameter int SEL_W     = 3,
  parameter int DIV_W     = 2,
  parameter int SEL_SAT   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             expired_o
);

  localparam int MAX_LOG2 = BASE_LOG2 + SEL_SAT + (2 ** DIV_W) - 1;
  localparam int CNT_W    = MAX_LOG2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] load_val;
  logic             cnt_en;
  int unsigned      shamt;

  always_comb begin
    shamt    = sbw_pkg::wait_log2(BASE_LOG2, 32'(sel_i), 32'(div_i), SEL_SAT);
    // length minus one; at the top shift the wrap gives all ones
    load_val = (CNT_W'(1) << shamt) - CNT_W'(1);
  end

  always_comb begin
    cnt_en = load_i | (run_i & (|cnt_q));
    cnt_d  = cnt_q;
    if (load_i)    cnt_d = load_val;
    else if (run_i) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl #(
  parameter int BASE_LOG2   = 13,
  parameter int SEL_W       = 3,
  parameter int DIV_W       = 2,
  parameter int SEL_SAT     = 5,
  parameter int N_IRQ       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             sby_en,
  input  logic             nmi_pin,
  input  logic [N_IRQ-1:0] irq_pin,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             irq_mask,
  input  logic             res_pin_n,
  input  logic             hwsby_pin_n,
  input  logic [SEL_W-1:0] settle_sel,
  input  logic [DIV_W-1:0] div_sel,
  output logic             osc_en,
  output logic             clk_gate_en,
  output logic             irq_start,
  output logic             rst_start,
  output logic             hw_sby
);
  import sbw_pkg::*;

  localparam int                PIN_W   = N_IRQ + 3;
  localparam logic [PIN_W-1:0]  PIN_RST = {1'b1, 1'b1, 1'b0, {N_IRQ{1'b0}}};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // pin synchronizer
  logic [PIN_W-1:0] pin_raw;
  logic [PIN_W-1:0] pin_s;
  logic             hw_s;
  logic             res_s;
  logic             nmi_s;
  logic [N_IRQ-1:0] irq_s;

  assign pin_raw = {hwsby_pin_n, res_pin_n, nmi_pin, irq_pin};

  sbw_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(srst_n),
    .d_i  (pin_raw),
    .q_o  (pin_s)
  );

  assign hw_s  = pin_s[N_IRQ+2];
  assign res_s = pin_s[N_IRQ+1];
  assign nmi_s = pin_s[N_IRQ];
  assign irq_s = pin_s[N_IRQ-1:0];

  // wake qualification
  logic wake;

  sbw_wake_qual #(.N_IRQ(N_IRQ)) u_qual (
    .nmi_i     (nmi_s),
    .irq_i     (irq_s),
    .irq_en_i  (irq_en),
    .irq_mask_i(irq_mask),
    .wake_o    (wake)
  );

  // sequencer
  sbw_state_e st_q;
  sbw_state_e st_d;
  logic       expired;
  logic       tmr_load;
  logic       tmr_run;

  always_comb begin
    st_d = st_q;
    if (!hw_s) begin
      st_d = ST_HW_STANDBY;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (!res_s)                  st_d = ST_RST_HOLD;
          else if (sleep_req && sby_en) st_d = ST_STANDBY;
        end
        ST_STANDBY: begin
          if (!res_s)     st_d = ST_RST_HOLD;
          else if (wake)  st_d = ST_SETTLING;
        end
        ST_SETTLING: begin
          if (!res_s)       st_d = ST_RST_HOLD;
          else if (expired) st_d = ST_RUN;
        end
        ST_RST_HOLD: begin
          if (res_s) st_d = ST_RUN;
        end
        ST_HW_STANDBY: st_d = ST_RST_HOLD;
        default:       st_d = ST_RUN;
      endcase
    end
  end

  assign tmr_load = (st_q == ST_STANDBY) && (st_d == ST_SETTLING);
  assign tmr_run  = (st_q == ST_SETTLING);

  sbw_settle_timer #(
    .BASE_LOG2(BASE_LOG2),
    .SEL_W    (SEL_W),
    .DIV_W    (DIV_W),
    .SEL_SAT  (SEL_SAT)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (srst_n),
    .load_i   (tmr_load),
    .run_i    (tmr_run),
    .sel_i    (settle_sel),
    .div_i    (div_sel),
    .expired_o(expired)
  );

  logic irq_start_d;
  logic rst_start_d;

  assign irq_start_d = (st_q == ST_SETTLING) && (st_d == ST_RUN);
  assign rst_start_d = (st_q == ST_RST_HOLD) && (st_d == ST_RUN);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q      <= ST_RUN;
      irq_start <= 1'b0;
      rst_start <= 1'b0;
    end else begin
      st_q      <= st_d;
      irq_start <= irq_start_d;
      rst_start <= rst_start_d;
    end
  end

  // state-decoded controls
  always_comb begin
    osc_en      = 1'b0;
    clk_gate_en = 1'b0;
    unique case (st_q)
      ST_RUN:        begin osc_en = 1'b1; clk_gate_en = 1'b1; end
      ST_SETTLING:   begin osc_en = 1'b1; clk_gate_en = 1'b0; end
      ST_RST_HOLD:   begin osc_en = 1'b1; clk_gate_en = 1'b1; end
      ST_STANDBY,
      ST_HW_STANDBY: begin osc_en = 1'b0; clk_gate_en = 1'b0; end
      default:       begin osc_en = 1'b1; clk_gate_en = 1'b1; end
    endcase
  end

  assign hw_sby = (st_q == ST_HW_STANDBY);

endmodule

// File: rtl/standby_wake_ctrl_chk.sv
module standby_wake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic clk_gate_en,
  input logic irq_start,
  input logic rst_start,
  input logic hw_sby
);

  // R9
  hwsby_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_sby |-> (!osc_en && !clk_gate_en));

  // R5
  clk_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate_en |-> osc_en);

  // R6
  irq_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_start |=> !irq_start);

  // R6
  irq_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_start |-> (clk_gate_en && $past(osc_en) && !$past(clk_gate_en)));

  // R7
  rst_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start |=> !rst_start);

  // R7
  rst_after_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start |-> (clk_gate_en && $past(clk_gate_en)));

  // R8
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_start && rst_start));

endmodule

bind standby_wake_ctrl standby_wake_ctrl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .osc_en     (osc_en),
  .clk_gate_en(clk_gate_en),
  .irq_start  (irq_start),
  .rst_start  (rst_start),
  .hw_sby     (hw_sby)
);

// File: tb/standby_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module standby_wake_ctrl_tb_top;

  localparam int BASE = 2;
  localparam int NI   = 3;
  localparam int SS   = 2;
  localparam int NV   = 10;

  // vector: sel[6:4] div[3:2] src[1:0]  (src 0 = nmi, 1..3 = irq line src-1)
  localparam logic [6:0] VEC [NV] = '{
    {3'd0, 2'd0, 2'd0}, {3'd1, 2'd0, 2'd1}, {3'd2, 2'd1, 2'd2},
    {3'd3, 2'd0, 2'd3}, {3'd4, 2'd2, 2'd0}, {3'd5, 2'd0, 2'd1},
    {3'd6, 2'd0, 2'd2}, {3'd7, 2'd3, 2'd3}, {3'd0, 2'd3, 2'd0},
    {3'd4, 2'd3, 2'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n, sleep_req, sby_en, nmi_pin, irq_mask, res_pin_n, hwsby_pin_n;
  logic [NI-1:0] irq_pin, irq_en;
  logic [2:0]    settle_sel;
  logic [1:0]    div_sel;
  logic          osc_en, clk_gate_en, irq_start, rst_start, hw_sby;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  standby_wake_ctrl #(.BASE_LOG2(BASE), .N_IRQ(NI), .SYNC_STAGES(SS)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sby_en(sby_en),
    .nmi_pin(nmi_pin), .irq_pin(irq_pin), .irq_en(irq_en), .irq_mask(irq_mask),
    .res_pin_n(res_pin_n), .hwsby_pin_n(hwsby_pin_n), .settle_sel(settle_sel),
    .div_sel(div_sel), .osc_en(osc_en), .clk_gate_en(clk_gate_en),
    .irq_start(irq_start), .rst_start(rst_start), .hw_sby(hw_sby));

  function automatic int exp_wait(int s, int d);
    int e;
    e = (s > 5) ? 5 : s;
    return 1 << (BASE + e + d);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_src(int src, logic v);
    if (src == 0) nmi_pin = v;
    else          irq_pin[src-1] = v;
  endtask

  task automatic enter_standby();
    sby_en = 1'b1; sleep_req = 1'b1;
    tick(1);
    sleep_req = 1'b0;
    chk("R2 standby osc_en", int'(osc_en), 0);
    chk("R2 standby clk_gate_en", int'(clk_gate_en), 0);
  endtask

  task automatic count_settle(output int n);
    n = 0;
    do begin
      tick(1);
      if (osc_en && !clk_gate_en) n++;
    end while (!clk_gate_en && n < 5000);
  endtask

  initial begin
    int n;
    int seen;
    rst_n = 1'b0; sleep_req = 1'b0; sby_en = 1'b0; nmi_pin = 1'b0; irq_pin = '0;
    irq_en = '1; irq_mask = 1'b0; res_pin_n = 1'b1; hwsby_pin_n = 1'b1;
    settle_sel = 3'd0; div_sel = 2'd0;
    tick(2);
    // R1 reset state
    chk("R1 osc_en", int'(osc_en), 1);
    chk("R1 clk_gate_en", int'(clk_gate_en), 1);
    chk("R1 irq_start", int'(irq_start), 0);
    chk("R1 rst_start", int'(rst_start), 0);
    chk("R1 hw_sby", int'(hw_sby), 0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 clk after release", int'(clk_gate_en), 1);

    // R2 sleep without enable is ignored
    sby_en = 1'b0; sleep_req = 1'b1;
    tick(1);
    sleep_req = 1'b0;
    tick(2);
    chk("R2 no-enable osc_en", int'(osc_en), 1);
    chk("R2 no-enable clk_gate_en", int'(clk_gate_en), 1);

    // R5/R6 vector walk over select, divider and source
    for (int i = 0; i < NV; i++) begin
      settle_sel = VEC[i][6:4];
      div_sel    = VEC[i][3:2];
      enter_standby();
      set_src(int'(VEC[i][1:0]), 1'b1);
      count_settle(n);
      chk($sformatf("R5 wait vec%0d", i), n, exp_wait(int'(VEC[i][6:4]), int'(VEC[i][3:2])));
      chk($sformatf("R6 irq_start high vec%0d", i), int'(irq_start), 1);
      set_src(int'(VEC[i][1:0]), 1'b0);
      tick(1);
      chk($sformatf("R6 irq_start low vec%0d", i), int'(irq_start), 0);
      tick(4);
    end

    // R4 disabled and masked lines do not wake; R3 nmi ignores mask
    settle_sel = 3'd0; div_sel = 2'd0;
    enter_standby();
    irq_en = 3'b110; irq_pin[0] = 1'b1;
    tick(8);
    chk("R4 disabled line osc_en", int'(osc_en), 0);
    irq_en = 3'b111; irq_mask = 1'b1;
    tick(8);
    chk("R4 masked line osc_en", int'(osc_en), 0);
    nmi_pin = 1'b1;
    count_settle(n);
    chk("R3 nmi wake under mask", n, exp_wait(0, 0));
    nmi_pin = 1'b0; irq_pin = '0; irq_mask = 1'b0;
    tick(4);

    // R7 reset pin in standby
    enter_standby();
    res_pin_n = 1'b0;
    tick(2);
    chk("R7 clk still off", int'(clk_gate_en), 0);
    tick(1);
    chk("R7 clk immediate", int'(clk_gate_en), 1);
    chk("R7 osc immediate", int'(osc_en), 1);
    tick(5);
    chk("R7 no rst_start while low", int'(rst_start), 0);
    res_pin_n = 1'b1;
    tick(2);
    chk("R7 rst_start not early", int'(rst_start), 0);
    tick(1);
    chk("R7 rst_start pulse", int'(rst_start), 1);
    tick(1);
    chk("R7 rst_start single", int'(rst_start), 0);
    tick(2);

    // R8 reset aborts settling
    settle_sel = 3'd4; div_sel = 2'd3;
    enter_standby();
    nmi_pin = 1'b1;
    tick(20);
    chk("R8 settling osc_en", int'(osc_en), 1);
    chk("R8 settling clk_gate_en", int'(clk_gate_en), 0);
    nmi_pin = 1'b0; res_pin_n = 1'b0;
    tick(3);
    chk("R8 clk on abort", int'(clk_gate_en), 1);
    res_pin_n = 1'b1;
    tick(3);
    chk("R8 rst_start after abort", int'(rst_start), 1);
    seen = 0;
    repeat (600) begin
      tick(1);
      if (irq_start) seen++;
    end
    chk("R8 no irq_start after abort", seen, 0);

    // R9 hardware standby beats reset; R10 release path
    hwsby_pin_n = 1'b0; res_pin_n = 1'b0;
    tick(3);
    chk("R9 hw_sby", int'(hw_sby), 1);
    chk("R9 osc_en off", int'(osc_en), 0);
    chk("R9 clk off", int'(clk_gate_en), 0);
    tick(5);
    chk("R9 hw_sby holds over reset", int'(hw_sby), 1);
    hwsby_pin_n = 1'b1;
    tick(3);
    chk("R10 clk on release", int'(clk_gate_en), 1);
    chk("R10 hw_sby off", int'(hw_sby), 0);
    chk("R10 no rst_start while reset low", int'(rst_start), 0);
    res_pin_n = 1'b1;
    tick(3);
    chk("R10 rst_start after reset rises", int'(rst_start), 1);
    tick(2);

    // R9 during settling, R10 release with reset high
    settle_sel = 3'd3; div_sel = 2'd1;
    enter_standby();
    irq_pin[1] = 1'b1;
    tick(10);
    hwsby_pin_n = 1'b0;
    tick(3);
    chk("R9 hw_sby from settling", int'(hw_sby), 1);
    chk("R9 osc off from settling", int'(osc_en), 0);
    irq_pin[1] = 1'b0; hwsby_pin_n = 1'b1;
    tick(3);
    chk("R10 clk on release", int'(clk_gate_en), 1);
    tick(1);
    chk("R10 rst_start next cycle", int'(rst_start), 1);
    seen = 0;
    repeat (100) begin
      tick(1);
      if (irq_start) seen++;
    end
    chk("R9 no irq_start after hw standby", seen, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule